// File: doc/BRIEF.md
# PWM Event Interrupt and Trigger Unit

This unit sits beside a PWM timebase and watches its counter. Each cycle it compares the counter value with zero, with the period (load) value and with two compare thresholds. A compare match is reported as one of two events, chosen by the timebase's current count direction. The result is six event sources. A counter value produces an event only when the counter arrives at it. A counter that is halted on a matching value therefore yields a single event and does not repeat it.

Two independent enable masks, held in one configuration word, decide what each event does. One mask lets an event raise the interrupt line. The other lets it fire a one-cycle conversion-trigger pulse. Every event is latched into a raw status word whatever the masks hold. A masked view shows only the latched events whose interrupt is enabled. Software clears events by writing ones to the masked view.

The register port is a plain strobe interface with a combinational read. It has no stream data, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pwm_evt_unit`

## Requirements
- R1: Event bits are: bit 0 counter equals zero, bit 1 counter equals load, bit 2 counter equals compare A while `cnt_up_i`=1, bit 3 compare A while `cnt_up_i`=0, bit 4 compare B while up, bit 5 compare B while down. Bits 2 and 3 never fire together, and bits 4 and 5 never fire together.
- R2: The configuration word is at address 0 and is read/write. Interrupt enables occupy bits 5:0 and trigger enables occupy bits 13:8, both in the event order of R1. Bits 7:6 and 31:14 always read 0.
- R3: A match is detected only in the first cycle after reset, or in a cycle whose counter value differs from the previous cycle's counter value. A counter held on one value gives at most one event.
- R4: The raw status at address 1 (bits 5:0, other bits 0) latches every event regardless of either mask. A bit is set from the cycle after its event. Writes to address 1 are ignored.
- R5: The masked status at address 2 reads the raw status ANDed with the interrupt enables.
- R6: Writing to address 2 clears every raw bit whose write-data bit in 5:0 is 1, and leaves the other bits unchanged. If a new event hits a bit in the same cycle as its clear, the bit stays set.
- R7: `irq_o` is the OR of the masked status bits, so it is high from the cycle after an enabled event until that event is cleared.
- R8: `trig_o` is high for exactly one cycle, the cycle after any event whose trigger enable is set. It does not identify the event. Events whose trigger enable is clear produce no pulse.
- R9: After reset all registers read 0, and `irq_o` and `trig_o` are 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Timebase counter value |
| cnt_up_i | input | 1 | 1 while the timebase counts up |
| load_i | input | CNT_W | Period (load) value |
| cmpa_i | input | CNT_W | Compare A threshold |
| cmpb_i | input | CNT_W | Compare B threshold |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request level |
| trig_o | output | 1 | Conversion-trigger pulse |

## Verification
On every cycle, assertions check four properties. Up and down compare events are mutually exclusive. A held counter value raises no event. An event or a clear takes effect on the raw status one cycle later, with the set winning over the clear. `irq_o` is never high while the raw status is empty. Only the directed scenarios can show the rest: the exact bit each event lands on, the readback layout of the configuration word, the one-cycle width of the trigger pulse, and the fact that writes to the raw view change nothing.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int unsigned NUM_EVT = 6;
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned TRIG_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG    = 2'd0,
    ADDR_RAW    = 2'd1,
    ADDR_MASKED = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  typedef enum int unsigned {
    EV_ZERO   = 0,
    EV_LOAD   = 1,
    EV_A_UP   = 2,
    EV_A_DOWN = 3,
    EV_B_UP   = 4,
    EV_B_DOWN = 5
  } evt_idx_e;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
  import pwm_evt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_up_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  input  evt_vec_t         trig_en_i,
  output evt_vec_t         evt_o,
  output logic             trig_o
);
  logic [CNT_W-1:0] prev_cnt_q;
  logic             prev_vld_q;
  logic             fresh;
  logic [CNT_W-1:0] cmp_val [NUM_CMP];
  evt_vec_t         evt;

  assign cmp_val[0] = cmpa_i;
  assign cmp_val[1] = cmpb_i;

  // A value counts as newly visited on the first cycle or when it changed.
  assign fresh = !prev_vld_q || (cnt_i != prev_cnt_q);

  assign evt[EV_ZERO] = fresh && (cnt_i == '0);
  assign evt[EV_LOAD] = fresh && (cnt_i == load_i);

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    logic hit;
    assign hit = fresh && (cnt_i == cmp_val[c]);
    assign evt[2 + 2*c]     = hit &&  cnt_up_i;
    assign evt[2 + 2*c + 1] = hit && !cnt_up_i;
  end

  assign evt_o = evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cnt_q <= '0;
      prev_vld_q <= 1'b0;
      trig_o     <= 1'b0;
    end else begin
      prev_cnt_q <= cnt_i;
      prev_vld_q <= 1'b1;
      trig_o     <= |(evt & trig_en_i);
    end
  end

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_o[EV_A_UP] && evt_o[EV_A_DOWN]) && !(evt_o[EV_B_UP] && evt_o[EV_B_DOWN])); // R1

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (cnt_i == $past(cnt_i))) |-> (evt_o == '0)); // R3
endmodule

// File: rtl/pwm_evt_status.sv
module pwm_evt_status
  import pwm_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt_i,
  input  evt_vec_t clr_i,
  input  evt_vec_t int_en_i,
  output evt_vec_t raw_o,
  output evt_vec_t masked_o,
  output logic     irq_o
);
  evt_vec_t raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_i) | evt_i;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & int_en_i;
  assign irq_o    = |masked_o;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R6

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i != '0) && (evt_i == '0)) |=> ((raw_q & $past(clr_i)) == '0)); // R6
endmodule

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  evt_vec_t          raw_i,
  input  evt_vec_t          masked_i,
  output evt_vec_t          int_en_o,
  output evt_vec_t          trig_en_o,
  output evt_vec_t          clr_o,
  output logic [REG_W-1:0]  reg_rdata_o
);
  evt_vec_t int_en_q, trig_en_q;
  logic     unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[REG_W-1:TRIG_LSB+NUM_EVT],
                          reg_wdata_i[TRIG_LSB-1:NUM_EVT]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en_q  <= '0;
      trig_en_q <= '0;
    end else if (reg_wr_i && (reg_addr_i == ADDR_CFG)) begin
      int_en_q  <= reg_wdata_i[NUM_EVT-1:0];
      trig_en_q <= reg_wdata_i[TRIG_LSB +: NUM_EVT];
    end
  end

  assign clr_o = (reg_wr_i && (reg_addr_i == ADDR_MASKED)) ? reg_wdata_i[NUM_EVT-1:0] : '0;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CFG: begin
        reg_rdata_o[NUM_EVT-1:0]         = int_en_q;
        reg_rdata_o[TRIG_LSB +: NUM_EVT] = trig_en_q;
      end
      ADDR_RAW:    reg_rdata_o[NUM_EVT-1:0] = raw_i;
      ADDR_MASKED: reg_rdata_o[NUM_EVT-1:0] = masked_i;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign int_en_o  = int_en_q;
  assign trig_en_o = trig_en_q;

  AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_CFG) |-> ((reg_rdata_o[REG_W-1:TRIG_LSB+NUM_EVT] == '0) &&
                                  (reg_rdata_o[TRIG_LSB-1:NUM_EVT] == '0))); // R2
endmodule

// File: rtl/pwm_evt_unit.sv
module pwm_evt_unit
  import pwm_evt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_up_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic             trig_o
);
  evt_vec_t evt, raw, masked, int_en, trig_en, clr;

  pwm_evt_detect #(.CNT_W(CNT_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_i    (cnt_i),
    .cnt_up_i (cnt_up_i),
    .load_i   (load_i),
    .cmpa_i   (cmpa_i),
    .cmpb_i   (cmpb_i),
    .trig_en_i(trig_en),
    .evt_o    (evt),
    .trig_o   (trig_o)
  );

  pwm_evt_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .clr_i   (clr),
    .int_en_i(int_en),
    .raw_o   (raw),
    .masked_o(masked),
    .irq_o   (irq_o)
  );

  pwm_evt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .raw_i      (raw),
    .masked_i   (masked),
    .int_en_o   (int_en),
    .trig_en_o  (trig_en),
    .clr_o      (clr),
    .reg_rdata_o(reg_rdata_o)
  );

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw != '0)); // R7
endmodule

// File: tb/test_pwm_evt_unit.sv
`timescale 1ns/1ps
module test_pwm_evt_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cnt = 16'd3, load = 16'd20, cmpa = 16'd5, cmpb = 16'd12;
  logic        up = 1'b1;
  logic        wr = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq, trig;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pwm_evt_unit #(.CNT_W(16)) i_pwm_evt_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_up_i(up), .load_i(load),
    .cmpa_i(cmpa), .cmpb_i(cmpb), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .trig_o(trig)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Called at a negedge; drives, then waits to the next negedge.
  task automatic step(logic [15:0] v, logic dir);
    cnt = v; up = dir;
    @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = 0;
  endtask

  task automatic clear_all();
    wreg(2'd2, 32'h3F);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R9 reset readback", d, 0);
    end
    chk("R9 reset irq", {31'b0, irq}, 0);
    chk("R9 reset trig", {31'b0, trig}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wreg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R2 cfg reserved bits zero", d, 32'h0000_3F3F);
    wreg(2'd0, 32'h0000_2104);
    rd(2'd0, d);
    chk("R2 cfg readback", d, 32'h0000_2104);
    wreg(2'd0, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    step(16'd0, 1'b1);
    rd(2'd1, d); chk("R4 zero event bit0 with masks off", d, 32'h01);
    chk("R7 no irq when disabled", {31'b0, irq}, 0);
    step(16'd4, 1'b1); step(16'd5, 1'b1);
    rd(2'd1, d); chk("R1 compA up bit2", d, 32'h05);
    step(16'd6, 1'b0); step(16'd5, 1'b0);
    rd(2'd1, d); chk("R1 compA down bit3", d, 32'h0D);
    step(16'd12, 1'b1); step(16'd13, 1'b0); step(16'd12, 1'b0);
    rd(2'd1, d); chk("R1 compB up and down bits4,5", d, 32'h3D);
    step(16'd20, 1'b1);
    rd(2'd1, d); chk("R1 load bit1", d, 32'h3F);
    clear_all();
    rd(2'd1, d); chk("R6 clear all raw", d, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    wreg(2'd0, 32'h0000_0004);
    step(16'd4, 1'b1); step(16'd5, 1'b1); step(16'd0, 1'b0);
    rd(2'd2, d); chk("R5 masked shows only enabled", d, 32'h04);
    chk("R7 irq high", {31'b0, irq}, 1);
    wreg(2'd1, 32'h3F);
    rd(2'd1, d); chk("R4 write to raw ignored", d, 32'h05);
    wreg(2'd2, 32'h04);
    rd(2'd1, d); chk("R6 W1C clears only bit2 in raw", d, 32'h01);
    rd(2'd2, d); chk("R5 masked after clear", d, 0);
    chk("R7 irq low after clear", {31'b0, irq}, 0);
    clear_all();
    wreg(2'd0, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    step(16'd7, 1'b1);
    cnt = 16'd5; up = 1'b1; wr = 1; addr = 2'd2; wdata = 32'h04;
    @(negedge clk);
    wr = 0; wdata = 0;
    rd(2'd1, d); chk("R6 set wins over clear", d, 32'h04);
    clear_all();
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    wreg(2'd0, 32'h0000_0100);
    step(16'd1, 1'b0);
    chk("R8 no trigger without event", {31'b0, trig}, 0);
    step(16'd0, 1'b0);
    chk("R8 trigger pulse", {31'b0, trig}, 1);
    step(16'd0, 1'b0);
    chk("R8 trigger one cycle only", {31'b0, trig}, 0);
    clear_all();
    step(16'd0, 1'b0); step(16'd0, 1'b0);
    rd(2'd1, d); chk("R3 held counter no re-detect", d, 0);
    chk("R3 held counter no trigger", {31'b0, trig}, 0);
    step(16'd5, 1'b1);
    chk("R8 disabled event no trigger", {31'b0, trig}, 0);
    clear_all();
    wreg(2'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_events();
    t_masked();
    t_set_wins();
    t_trigger();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule